// File: doc/BRIEF.md
# Serial programmer command parser

This block sits behind a byte-wide serial receiver and transmitter and turns the incoming host byte stream into framed commands. Every opcode has a fixed parameter byte count taken from a per-opcode length function. The parser therefore needs no length fields in the stream. It gathers the parameter bytes, builds multibyte values least significant byte first, and hands each complete command to a downstream operation-buffer port as one single-cycle strobe.

Replies depend on the opcode and on the outcome. The buffer-initialize command answers ACK. Single-byte write and append commands stay silent when they succeed and answer NAK when the buffer is full. A capability query answers ACK followed by a 32-bit map of the opcodes that are implemented. Any other byte in opcode position is rejected at once with NAK.

The receive side has a ready signal. The parser takes no new byte while a reply is still being sent or while a command is being carried out. This keeps replies in the same order as the commands.

Top module: `ser_cmd_parser`

## Requirements
- R1: After reset, tx_valid and op_valid are low and rx_ready is high.
- R2: An opcode byte other than 0x02, 0x07, 0x08 or 0x09 (including every value of 32 or more) produces exactly one reply byte NAK = 0x15. It consumes no parameter bytes and issues no downstream operation.
- R3: Opcode 0x02 takes no parameters and replies with five bytes: ACK = 0x06, then a 32-bit map, least significant byte first, in which bit N is set exactly when opcode N is implemented (value 0x00000384).
- R4: Opcode 0x07 takes no parameters. It issues one operation with op_kind = 0 and replies ACK (0x06), whatever the level of op_full.
- R5: Opcode 0x08 takes four parameter bytes: address bits 7:0, then 15:8, then 23:16, then the data byte. With op_full low, it issues one operation with op_kind = 1 and the assembled op_addr and op_data, and sends no reply.
- R6: Opcode 0x09 takes one parameter byte (data). With op_full low, it issues one operation with op_kind = 2, op_data equal to that byte and op_addr = 0, and sends no reply.
- R7: If op_full is high when a 0x08 or 0x09 command completes, the parser replies with one NAK and issues no operation.
- R8: No operation and no reply is produced before the last parameter byte of a command has been accepted. op_valid is a single-cycle strobe in the cycle after that byte.
- R9: Reply bytes are presented on tx_data one at a time and held steady while tx_ready is low. rx_ready is low while a reply is pending or a command is being carried out. A byte offered on rx_valid while rx_ready is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Received byte present |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Parser accepts a byte this cycle |
| tx_valid | output | 1 | Reply byte present |
| tx_data | output | 8 | Reply byte |
| tx_ready | input | 1 | Transmitter takes the reply byte |
| op_valid | output | 1 | Single-cycle strobe: operation issued |
| op_kind | output | 2 | 0 initialize, 1 write, 2 append |
| op_addr | output | 24 | Write address (0 for other kinds) |
| op_data | output | 8 | Write or append data byte |
| op_full | input | 1 | Downstream buffer cannot take a write |

## Verification
The bench sweeps all 256 opcode values. It catches a parser that treats an unimplemented or out-of-range byte as a command and then swallows the following bytes as parameters, which would show as a missing NAK and a desynchronised stream. For the write command it uses an address that differs with every opcode and checks the issued address. A byte-order slip would swap the low and high address bytes. It also stops after three of the four parameter bytes to catch an operation issued too early. With the buffer full it confirms that write and append answer NAK and issue nothing, while initialize still answers ACK. It stalls the transmitter in the middle of the capability reply to check that the bytes stay stable, and offers a stray byte while receive is not ready. A parser that took that byte would add an extra NAK to the reply stream.

// File: rtl/ser_cmd_pkg.sv
package ser_cmd_pkg;
  localparam int OP_SPACE = 32;
  localparam logic [7:0] RSP_ACK = 8'h06;
  localparam logic [7:0] RSP_NAK = 8'h15;
  localparam logic [7:0] OPC_CAPS   = 8'h02;
  localparam logic [7:0] OPC_INIT   = 8'h07;
  localparam logic [7:0] OPC_WRITE  = 8'h08;
  localparam logic [7:0] OPC_APPEND = 8'h09;

  typedef enum logic [1:0] {
    OPK_INIT   = 2'd0,
    OPK_WRITE  = 2'd1,
    OPK_APPEND = 2'd2
  } opkind_e;

  // Bit N set when opcode N is implemented.
  function automatic logic [OP_SPACE-1:0] op_caps();
    logic [OP_SPACE-1:0] m;
    m = '0;
    m[OPC_CAPS[4:0]]   = 1'b1;
    m[OPC_INIT[4:0]]   = 1'b1;
    m[OPC_WRITE[4:0]]  = 1'b1;
    m[OPC_APPEND[4:0]] = 1'b1;
    return m;
  endfunction

  function automatic logic op_supported(input logic [7:0] op);
    logic [OP_SPACE-1:0] m;
    m = op_caps();
    return (int'(op) < OP_SPACE) && m[op[4:0]];
  endfunction

  // Fixed parameter byte count per opcode.
  function automatic logic [2:0] op_param_len(input logic [7:0] op);
    case (op)
      OPC_WRITE:  return 3'd4;
      OPC_APPEND: return 3'd1;
      default:    return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/ser_cmd_framer.sv
module ser_cmd_framer
  import ser_cmd_pkg::*;
#(
  parameter int PARAM_MAX = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rx_valid,
  input  logic [7:0]             rx_data,
  input  logic                   rx_ready,
  output logic                   done,
  output logic                   bad,
  output logic [7:0]             opcode,
  output logic [PARAM_MAX*8-1:0] params
);
  localparam int IDX_W = $clog2(PARAM_MAX + 1);

  logic             collecting;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] need;
  logic             take;

  assign take = rx_valid && rx_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      collecting <= 1'b0;
      idx        <= '0;
      need       <= '0;
      done       <= 1'b0;
      bad        <= 1'b0;
      opcode     <= '0;
      params     <= '0;
    end else begin
      done <= 1'b0;
      bad  <= 1'b0;
      if (take) begin
        if (!collecting) begin
          opcode <= rx_data;
          params <= '0;
          idx    <= '0;
          if (!op_supported(rx_data)) begin
            done <= 1'b1;
            bad  <= 1'b1;
          end else if (op_param_len(rx_data) == 3'd0) begin
            done <= 1'b1;
          end else begin
            collecting <= 1'b1;
            need       <= IDX_W'(op_param_len(rx_data));
          end
        end else begin
          params[int'(idx)*8 +: 8] <= rx_data;
          idx <= idx + IDX_W'(1);
          if (idx + IDX_W'(1) == need) begin
            collecting <= 1'b0;
            done       <= 1'b1;
          end
        end
      end
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/ser_reply_tx.sv
module ser_reply_tx #(
  parameter int REPLY_MAX = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic [$clog2(REPLY_MAX+1)-1:0] load_len,
  input  logic [REPLY_MAX*8-1:0] load_bytes,
  output logic                   tx_valid,
  output logic [7:0]             tx_data,
  input  logic                   tx_ready,
  output logic                   idle
);
  localparam int CNT_W = $clog2(REPLY_MAX + 1);

  logic [REPLY_MAX*8-1:0] sr;
  logic [CNT_W-1:0]       cnt;

  assign tx_valid = (cnt != '0);
  assign tx_data  = sr[7:0];
  assign idle     = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr  <= '0;
      cnt <= '0;
    end else if (load) begin
      sr  <= load_bytes;
      cnt <= load_len;
    end else if (tx_valid && tx_ready) begin
      sr  <= sr >> 8;
      cnt <= cnt - CNT_W'(1);
    end
  end

  // R9
  load_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> idle);
  // R9
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));
endmodule

// File: rtl/ser_cmd_parser.sv
module ser_cmd_parser
  import ser_cmd_pkg::*;
#(
  parameter int PARAM_MAX = 4,
  parameter int REPLY_MAX = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  output logic        rx_ready,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  input  logic        tx_ready,
  output logic        op_valid,
  output logic [1:0]  op_kind,
  output logic [23:0] op_addr,
  output logic [7:0]  op_data,
  input  logic        op_full
);
  localparam int REPLY_W = REPLY_MAX * 8;
  localparam int CNT_W   = $clog2(REPLY_MAX + 1);

  logic                   frm_done;
  logic                   frm_bad;
  logic [7:0]             frm_op;
  logic [PARAM_MAX*8-1:0] frm_params;
  logic                   tx_idle;
  logic                   rsp_load;
  logic [CNT_W-1:0]       rsp_len;
  logic [REPLY_W-1:0]     rsp_bytes;
  opkind_e                kind;

  assign rx_ready = tx_idle && !frm_done;

  ser_cmd_framer #(.PARAM_MAX(PARAM_MAX)) framer_i (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .done(frm_done), .bad(frm_bad),
    .opcode(frm_op), .params(frm_params)
  );

  always_comb begin
    rsp_len   = '0;
    rsp_bytes = '0;
    op_valid  = 1'b0;
    kind      = OPK_INIT;
    op_addr   = '0;
    op_data   = '0;
    if (frm_done) begin
      if (frm_bad) begin
        rsp_len   = CNT_W'(1);
        rsp_bytes = REPLY_W'(RSP_NAK);
      end else begin
        case (frm_op)
          OPC_CAPS: begin
            rsp_len   = CNT_W'(5);
            rsp_bytes = REPLY_W'({op_caps(), RSP_ACK});
          end
          OPC_INIT: begin
            op_valid  = 1'b1;
            kind      = OPK_INIT;
            rsp_len   = CNT_W'(1);
            rsp_bytes = REPLY_W'(RSP_ACK);
          end
          OPC_WRITE: begin
            if (op_full) begin
              rsp_len   = CNT_W'(1);
              rsp_bytes = REPLY_W'(RSP_NAK);
            end else begin
              op_valid = 1'b1;
              kind     = OPK_WRITE;
              op_addr  = frm_params[23:0];
              op_data  = frm_params[31:24];
            end
          end
          OPC_APPEND: begin
            if (op_full) begin
              rsp_len   = CNT_W'(1);
              rsp_bytes = REPLY_W'(RSP_NAK);
            end else begin
              op_valid = 1'b1;
              kind     = OPK_APPEND;
              op_data  = frm_params[7:0];
            end
          end
          default: begin
            rsp_len   = CNT_W'(1);
            rsp_bytes = REPLY_W'(RSP_NAK);
          end
        endcase
      end
    end
  end

  assign op_kind  = kind;
  assign rsp_load = frm_done && (rsp_len != '0);

  ser_reply_tx #(.REPLY_MAX(REPLY_MAX)) reply_i (
    .clk(clk), .rst_n(rst_n), .load(rsp_load), .load_len(rsp_len),
    .load_bytes(rsp_bytes), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .idle(tx_idle)
  );

  // R2
  bad_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done && frm_bad |=> tx_valid && tx_data == RSP_NAK);
  // R3
  caps_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done && !frm_bad && frm_op == OPC_CAPS |=> tx_valid && tx_data == RSP_ACK);
endmodule

// File: tb/ser_cmd_parser_tb_top.sv
module ser_cmd_parser_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        tx_ready = 1'b1;
  logic        op_valid;
  logic [1:0]  op_kind;
  logic [23:0] op_addr;
  logic [7:0]  op_data;
  logic        op_full = 1'b0;

  int checks = 0;
  int fails  = 0;
  logic [7:0]  txq[$];
  logic [33:0] opq[$];

  always #5 clk = ~clk;

  ser_cmd_parser dut_i (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .op_valid(op_valid), .op_kind(op_kind),
    .op_addr(op_addr), .op_data(op_data), .op_full(op_full)
  );

  always @(negedge clk) if (rst_n) begin
    if (tx_valid && tx_ready) txq.push_back(tx_data);
    if (op_valid) opq.push_back({op_kind, op_addr, op_data});
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    while (!rx_ready) @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (12) @(negedge clk);
  endtask

  task automatic expect_tx(input int n, input logic [39:0] e, input string req);
    chk(txq.size() == n, req, "reply length", 64'(txq.size()), 64'(n));
    if (txq.size() == n)
      for (int i = 0; i < n; i++)
        chk(txq[i] == e[i*8 +: 8], req, "reply byte", 64'(txq[i]), 64'(e[i*8 +: 8]));
    txq.delete();
  endtask

  task automatic expect_op(input int n, input logic [33:0] e, input string req);
    chk(opq.size() == n, req, "op count", 64'(opq.size()), 64'(n));
    if (n == 1 && opq.size() == 1)
      chk(opq[0] == e, req, "op fields", 64'(opq[0]), 64'(e));
    opq.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] mask;
    logic [23:0] a;
    logic [7:0]  d;
    mask = (32'd1 << 2) | (32'd1 << 7) | (32'd1 << 8) | (32'd1 << 9);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!tx_valid, "R1", "tx_valid", 64'(tx_valid), 0);
    chk(!op_valid, "R1", "op_valid", 64'(op_valid), 0);
    chk(rx_ready, "R1", "rx_ready", 64'(rx_ready), 1);

    // Sweep of every opcode value with buffer space available
    for (int o = 0; o < 256; o++) begin
      logic [7:0] oc;
      oc = 8'(o);
      a  = 24'hA1B2C3 ^ {oc, ~oc, oc};
      d  = oc ^ 8'h3C;
      send(oc);
      if (oc == 8'h02) begin
        settle();
        expect_tx(5, {mask, 8'h06}, "R3");
        expect_op(0, '0, "R3");
      end else if (oc == 8'h07) begin
        settle();
        expect_tx(1, 40'h06, "R4");
        expect_op(1, {2'd0, 24'd0, 8'd0}, "R4");
      end else if (oc == 8'h08) begin
        send(a[7:0]); send(a[15:8]); send(a[23:16]);
        repeat (3) @(negedge clk);
        // R8 nothing before last parameter byte
        chk(opq.size() == 0 && txq.size() == 0, "R8", "early output",
            64'(opq.size() + txq.size()), 0);
        send(d);
        settle();
        expect_tx(0, '0, "R5");
        expect_op(1, {2'd1, a, d}, "R5");
      end else if (oc == 8'h09) begin
        send(d);
        settle();
        expect_tx(0, '0, "R6");
        expect_op(1, {2'd2, 24'd0, d}, "R6");
      end else begin
        settle();
        expect_tx(1, 40'h15, "R2");
        expect_op(0, '0, "R2");
      end
    end

    // Buffer full
    op_full = 1'b1;
    send(8'h08); send(8'h11); send(8'h22); send(8'h33); send(8'h44);
    settle();
    expect_tx(1, 40'h15, "R7");
    expect_op(0, '0, "R7");
    send(8'h09); send(8'h5A);
    settle();
    expect_tx(1, 40'h15, "R7");
    expect_op(0, '0, "R7");
    send(8'h07);
    settle();
    expect_tx(1, 40'h06, "R4");
    expect_op(1, {2'd0, 24'd0, 8'd0}, "R4");
    op_full = 1'b0;

    // Transmitter stall mid reply, stray byte while not ready
    @(posedge clk); #1 tx_ready = 1'b0;
    send(8'h02);
    repeat (6) @(negedge clk);
    chk(tx_valid && tx_data == 8'h06, "R9", "held byte", 64'(tx_data), 64'h06);
    chk(!rx_ready, "R9", "rx_ready during reply", 64'(rx_ready), 0);
    rx_valid = 1'b1; rx_data = 8'hFF;
    @(negedge clk);
    rx_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(tx_valid && tx_data == 8'h06, "R9", "still held", 64'(tx_data), 64'h06);
    chk(txq.size() == 0, "R9", "no transfer while stalled", 64'(txq.size()), 0);
    @(posedge clk); #1 tx_ready = 1'b1;
    settle();
    expect_tx(5, {mask, 8'h06}, "R9");
    expect_op(0, '0, "R9");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule